// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block runs one 8-bit successive-approximation conversion at a time. A start pulse from the serial front end puts the track/hold into hold. The block then steps a trial code across an external capacitive DAC, one bit for each tick of the internal conversion-clock enable, most significant bit first. At each tick it samples a single comparator bit and decides whether to keep the current trial bit. After a fixed window, counted in ticks, it returns the track/hold to track on its own. It then presents the code to the output shift path together with a one-cycle valid strobe and a corruption flag.

Between conversions the block counts ticks of tracking time. If a start arrives before the minimum acquisition time has passed, the hold is deferred until that time is met. In single mode, each conversion needs a fresh start pulse from a new control word. In continuous mode, the falling serial-clock edge of the last result bit, reported on `last_bit_fall`, starts the next conversion without a control word. Any serial-clock falling edge seen while in hold marks that result as corrupted.

The FSM has three states. `ST_TRACK` is idle tracking. `ST_ACQWAIT` means a start is pending while acquisition completes. `ST_HOLD` means the conversion is running. The transitions are as follows:
- `trig_ready` goes from `ST_TRACK` to `ST_HOLD` when a trigger arrives and acquisition is met.
- `trig_early` goes from `ST_TRACK` to `ST_ACQWAIT` when a trigger arrives before acquisition is met.
- `acq_done` goes from `ST_ACQWAIT` to `ST_HOLD`.
- `window_end` goes from `ST_HOLD` to `ST_TRACK`.

Top module: `sar_conv_seq`

## Requirements
- R1: `res_data` is the straight-binary code of the comparator threshold. With a comparator that reports 1 when the input is at or above `trial_code`, the result equals the input for inputs 0 to 255.
- R2: The first trial on entering hold is 80h, with only the MSB set. On each tick, the bit under test stays 1 if `comp_hi` is 1 and is cleared otherwise, and then the next lower bit is set for trial.
- R3: In `ST_TRACK` with acquisition met, a `conv_start` sampled on one clock edge drives `th_hold` high after that same edge.
- R4: Hold lasts exactly CONV_TICKS ticks of `tick`. On the edge of the last tick, `th_hold` falls and `res_valid` pulses for one cycle with the new `res_data`.
- R5: `res_corrupt` is 1 alongside a result if `sclk_fall` was seen while `th_hold` was high for that conversion. Otherwise it is 0.
- R6: After a conversion, hold does not begin again until at least ACQ_TICKS ticks of tracking have passed. A trigger that arrives earlier is deferred, not dropped.
- R7: When `conv_start` was given with `cont_mode`=1, a `last_bit_fall` pulse in `ST_TRACK` starts the next conversion with no new start.
- R8: In single mode (`cont_mode`=0 at the last start), `last_bit_fall` has no effect. `th_hold` stays low and no result appears.
- R9: A comparator that is always 0 (input below ground) gives 00h. A comparator that is always 1 (input above full scale) gives FFh.
- R10: After reset, `th_hold`, `trial_code`, `res_data`, `res_valid` and `res_corrupt` are all 0.
- R11: A `conv_start` during hold is ignored. The window length and the result are unchanged, and no extra conversion follows.
- R12: A `conv_start` with `cont_mode`=0 cancels continuous operation set up by an earlier start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Conversion-clock enable, one cycle per tick |
| conv_start | input | 1 | Pulse at the falling serial edge after a control word |
| cont_mode | input | 1 | Mode sampled with `conv_start`: 1 is continuous |
| sclk_fall | input | 1 | Pulse on each serial-clock falling edge |
| last_bit_fall | input | 1 | Pulse on the falling serial edge of the last result bit |
| comp_hi | input | 1 | Comparator: input is at or above the trial code |
| th_hold | output | 1 | Track/hold control: 1 is hold, 0 is track |
| trial_code | output | WIDTH | Trial code sent to the capacitive DAC |
| res_data | output | WIDTH | Latest conversion result |
| res_valid | output | 1 | One-cycle strobe when `res_data` is updated |
| res_corrupt | output | 1 | Serial activity was seen during the last hold |

## Verification
Every result has a fixed due point, and the directed tasks sample one negative edge after the clock edge that makes the result due:
- `th_hold` rises one clock after an accepted `conv_start`.
- Each bit decision appears on `trial_code` one clock after the tick that made it.
- `res_valid` and `res_data` follow the CONV_TICKS-th tick of hold by one clock.
- A deferred hold comes one clock after the ACQ_TICKS-th tracking tick.

The bench counts the ticks that fall inside hold and inside tracking at each rising edge. From these counts it compares the window length and acquisition length exactly, in ticks rather than wall time. For the "no effect" cases, it watches `th_hold` and `res_valid` over a span longer than a full conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_TRACK   = 2'd0,
        ST_ACQWAIT = 2'd1,
        ST_HOLD    = 2'd2
    } seq_state_t;

endpackage

// File: rtl/sar_tick_timer.sv
// Saturating tick counter: cleared by clr, advances on en, flags when LIMIT is reached.
module sar_tick_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic at_limit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (en && !at_limit) begin
            count <= count + 1'b1;
        end
    end

    assign at_limit = (count == LIM);

    // R6 / R4: the counter never runs past its limit
    p_no_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LIM);

    // R4: a clear always restarts the count
    p_clear_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

endmodule

// File: rtl/sar_bit_search.sv
// Binary-search register: one probe bit walks down from the MSB and is kept or cleared per comparator.
module sar_bit_search #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             comp_hi,
    output logic [WIDTH-1:0] trial,
    output logic [WIDTH-1:0] code
);
    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] probe;
    logic [WIDTH-1:0] code_nxt;
    logic             active;

    assign active = step && (probe != '0);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign code_nxt[b] = load                ? 1'b0    :
                             (active && probe[b]) ? comp_hi :
                                                    code[b];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            probe <= '0;
            code  <= '0;
        end else begin
            code <= code_nxt;
            if (load) begin
                probe <= TOP_BIT;
            end else if (active) begin
                probe <= probe >> 1;
            end
        end
    end

    assign trial = code | probe;

    // R2: at most one bit is under test
    p_probe_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(probe));

    // R2: the search opens on the MSB alone
    p_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (trial == TOP_BIT));

    // R2: comparator high keeps the tested bit
    p_keep_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !load && comp_hi) |=> ((code & $past(probe)) != '0));

    // R2: comparator low clears the tested bit
    p_clear_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !load && !comp_hi) |=> ((code & $past(probe)) == '0));

endmodule

// File: rtl/sar_conv_seq.sv
// Conversion sequencer: track/hold control, window and acquisition timing, result hand-off.
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int CONV_TICKS = 36,
    parameter int ACQ_TICKS  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             conv_start,
    input  logic             cont_mode,
    input  logic             sclk_fall,
    input  logic             last_bit_fall,
    input  logic             comp_hi,
    output logic             th_hold,
    output logic [WIDTH-1:0] trial_code,
    output logic [WIDTH-1:0] res_data,
    output logic             res_valid,
    output logic             res_corrupt
);
    localparam int WIN_LAST = CONV_TICKS - 1;

    seq_state_t       state, state_nxt;
    logic             cont_armed;
    logic             bad_flag;
    logic             trigger;
    logic             acq_met;
    logic             win_at;
    logic             win_end;
    logic             enter_hold;
    logic             in_hold;
    logic [WIDTH-1:0] code;

    assign in_hold    = (state == ST_HOLD);
    assign trigger    = conv_start || (cont_armed && last_bit_fall);
    assign win_end    = in_hold && tick && win_at;
    assign enter_hold = (state_nxt == ST_HOLD) && !in_hold;

    // window timer: runs only in hold
    sar_tick_timer #(.LIMIT(WIN_LAST)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!in_hold),
        .en       (tick),
        .at_limit (win_at)
    );

    // acquisition timer: runs only while tracking
    sar_tick_timer #(.LIMIT(ACQ_TICKS)) u_acq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (in_hold),
        .en       (tick),
        .at_limit (acq_met)
    );

    sar_bit_search #(.WIDTH(WIDTH)) u_search (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (enter_hold),
        .step    (in_hold && tick),
        .comp_hi (comp_hi),
        .trial   (trial_code),
        .code    (code)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_TRACK;
        end else begin
            state <= state_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_TRACK: begin
                if (trigger) begin
                    state_nxt = acq_met ? ST_HOLD : ST_ACQWAIT;  // trig_ready / trig_early
                end
            end
            ST_ACQWAIT: begin
                if (acq_met) begin
                    state_nxt = ST_HOLD;                          // acq_done
                end
            end
            ST_HOLD: begin
                if (win_end) begin
                    state_nxt = ST_TRACK;                         // window_end
                end
            end
            default: state_nxt = ST_TRACK;
        endcase
    end

    // outputs and mode bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cont_armed  <= 1'b0;
            bad_flag    <= 1'b0;
            res_data    <= '0;
            res_valid   <= 1'b0;
            res_corrupt <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if ((state == ST_TRACK) && conv_start) begin
                cont_armed <= cont_mode;
            end
            if (enter_hold) begin
                bad_flag <= 1'b0;
            end else if (in_hold && sclk_fall) begin
                bad_flag <= 1'b1;
            end
            if (win_end) begin
                res_data    <= code;
                res_valid   <= 1'b1;
                res_corrupt <= bad_flag || sclk_fall;
            end
        end
    end

    assign th_hold = in_hold;

    // R4: a result is always handed over in track mode
    p_track_at_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !th_hold);

    // R4: the valid strobe lasts a single cycle
    p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R4: the last window tick ends hold and delivers a result
    p_window_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (!th_hold && res_valid));

    // R6: hold never begins before acquisition is met
    p_hold_needs_acq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(th_hold) |-> $past(acq_met));

    // R8: in single mode, only a start can lead to hold
    p_single_needs_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_TRACK) && !cont_armed && !conv_start) |=> !th_hold);

endmodule

// File: tb/sar_conv_seq_bench.sv
module sar_conv_seq_bench;
    localparam int W    = 8;
    localparam int CONV = 12;
    localparam int ACQ  = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         conv_start = 1'b0;
    logic         cont_mode = 1'b0;
    logic         sclk_fall = 1'b0;
    logic         last_bit_fall = 1'b0;
    logic         comp_hi;
    logic         th_hold;
    logic [W-1:0] trial_code;
    logic [W-1:0] res_data;
    logic         res_valid;
    logic         res_corrupt;
    logic         tick;
    logic [1:0]   div = 2'd0;
    int           vin = 0;
    int           conv_ticks = 0;
    int           trk_ticks = 0;
    int           checks = 0;
    int           failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) div <= div + 2'd1;
    assign tick = (div == 2'd3);

    // comparator: input at or above the trial code
    always_comb comp_hi = (vin >= int'(trial_code));

    // tick counters sampled at the rising edge (pre-edge values)
    always @(posedge clk) begin
        if (tick && th_hold)  conv_ticks <= conv_ticks + 1;
        if (tick && !th_hold) trk_ticks  <= trk_ticks + 1;
    end

    sar_conv_seq #(.WIDTH(W), .CONV_TICKS(CONV), .ACQ_TICKS(ACQ)) u_sar_conv_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .conv_start    (conv_start),
        .cont_mode     (cont_mode),
        .sclk_fall     (sclk_fall),
        .last_bit_fall (last_bit_fall),
        .comp_hi       (comp_hi),
        .th_hold       (th_hold),
        .trial_code    (trial_code),
        .res_data      (res_data),
        .res_valid     (res_valid),
        .res_corrupt   (res_corrupt)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start(input bit cont);
        @(negedge clk);
        conv_start = 1'b1;
        cont_mode  = cont;
        @(negedge clk);
        conv_start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        bit got = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            if (res_valid) begin
                got = 1'b1;
                break;
            end
            @(negedge clk);
        end
        chk(req, int'(got), 1);
    endtask

    task automatic t_reset;
        chk("R10 hold", int'(th_hold), 0);
        chk("R10 trial", int'(trial_code), 0);
        chk("R10 data", int'(res_data), 0);
        chk("R10 valid", int'(res_valid), 0);
        chk("R10 corrupt", int'(res_corrupt), 0);
    endtask

    task automatic t_basic;
        int base;
        idle(40);
        vin  = 165;
        base = conv_ticks;
        pulse_start(1'b0);
        chk("R3 hold after start", int'(th_hold), 1);
        chk("R2 first trial", int'(trial_code), 128);
        wait_done("R4 done seen");
        chk("R4 window ticks", conv_ticks - base, CONV);
        chk("R4 back to track", int'(th_hold), 0);
        chk("R1 result", int'(res_data), 165);
        chk("R5 clean", int'(res_corrupt), 0);
        @(negedge clk);
        chk("R4 valid one cycle", int'(res_valid), 0);
    endtask

    task automatic run_one(input int v, input string req, input int exp);
        idle(40);
        vin = v;
        pulse_start(1'b0);
        wait_done(req);
        chk(req, int'(res_data), exp);
    endtask

    task automatic t_patterns;
        run_one(0,   "R1 zero", 0);
        run_one(255, "R1 full", 255);
        run_one(1,   "R1 one", 1);
        run_one(127, "R1 7F", 127);
        run_one(128, "R1 80", 128);
        run_one(90,  "R1 5A", 90);
    endtask

    task automatic t_clamp;
        run_one(-7,  "R9 below ground", 0);
        run_one(400, "R9 above full scale", 255);
    endtask

    task automatic t_bitrule(input int v, input int exp1, input int exp2);
        idle(40);
        vin = v;
        pulse_start(1'b0);
        while (!tick) @(negedge clk);
        @(negedge clk);
        chk("R2 first decision", int'(trial_code), exp1);
        while (!tick) @(negedge clk);
        @(negedge clk);
        chk("R2 second decision", int'(trial_code), exp2);
        wait_done("R2 done");
    endtask

    task automatic t_corrupt;
        idle(40);
        vin = 110;
        pulse_start(1'b0);
        idle(5);
        sclk_fall = 1'b1;
        @(negedge clk);
        sclk_fall = 1'b0;
        wait_done("R5 done");
        chk("R5 corrupt flagged", int'(res_corrupt), 1);
        chk("R5 data still searched", int'(res_data), 110);
        run_one(111, "R5 next clean data", 111);
        chk("R5 next clean flag", int'(res_corrupt), 0);
    endtask

    task automatic t_acq;
        int base;
        int seen = 0;
        run_one(50, "R6 prior", 50);
        vin  = 60;
        base = trk_ticks;
        pulse_start(1'b0);
        chk("R6 hold deferred", int'(th_hold), 0);
        for (int i = 0; i < 200; i++) begin
            if (th_hold) begin
                seen = 1;
                break;
            end
            @(negedge clk);
        end
        chk("R6 deferred hold begins", seen, 1);
        chk("R6 tracking ticks >= min", int'((trk_ticks - base) >= ACQ), 1);
        chk("R6 tracking ticks <= min+1", int'((trk_ticks - base) <= ACQ + 1), 1);
        wait_done("R6 done");
        chk("R6 result", int'(res_data), 60);
    endtask

    task automatic cont_step(input int v);
        idle(40);
        vin = v;
        last_bit_fall = 1'b1;
        @(negedge clk);
        last_bit_fall = 1'b0;
        chk("R7 hold on last bit", int'(th_hold), 1);
        wait_done("R7 done");
        chk("R7 result", int'(res_data), v);
    endtask

    task automatic t_continuous;
        idle(40);
        vin = 51;
        pulse_start(1'b1);
        wait_done("R7 first done");
        chk("R7 first result", int'(res_data), 51);
        cont_step(153);
        cont_step(15);
    endtask

    task automatic t_single;
        int busy = 0;
        run_one(33, "R12 single start", 33);
        idle(40);
        vin = 119;
        last_bit_fall = 1'b1;
        @(negedge clk);
        last_bit_fall = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (th_hold || res_valid) busy++;
            @(negedge clk);
        end
        chk("R8 R12 last bit ignored", busy, 0);
        chk("R8 result unchanged", int'(res_data), 33);
    endtask

    task automatic t_midstart;
        int base;
        int extra = 0;
        idle(40);
        vin  = 92;
        base = conv_ticks;
        pulse_start(1'b0);
        idle(10);
        pulse_start(1'b0);
        wait_done("R11 done");
        chk("R11 window unchanged", conv_ticks - base, CONV);
        chk("R11 result", int'(res_data), 92);
        for (int i = 0; i < 80; i++) begin
            if (th_hold) extra++;
            @(negedge clk);
        end
        chk("R11 no extra conversion", extra, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_patterns();
        t_clamp();
        t_bitrule(195, 192, 224);
        t_bitrule(67, 64, 96);
        t_corrupt();
        t_acq();
        t_continuous();
        t_single();
        t_midstart();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule